// File: doc/BRIEF.md
# I/O Page Translation Unit

This block translates the addresses that devices use for DMA into physical addresses. It holds a single-level table of 64-bit translation entries in on-chip storage. Each entry gives the physical page frame in its upper bits and two access-right bits in its lowest positions. A lookup request carries an I/O virtual address and a flag that marks it as a read or a write. One cycle after the request is accepted, the block returns four things: the page-aligned I/O address, the translated physical address, the mask of in-page offset bits and the permission granted. It also raises a fault flag when the access is not allowed.

The page size is `2**PAGE_SHIFT` bytes and the table holds `NUM_ENTRIES` entries. An update engine fills the table through a separate write port. An address whose page index falls past the end of the table does not stop the block. It returns a no-access result whose offset mask is all ones, and the requester handles it as a fault.

Top module: `iotx_translator`

## Requirements
- R1: Bits [1:0] of an entry encode access and appear unchanged on `rsp_perm`: 0 = none, 1 = read only, 2 = write only, 3 = read and write. Bit 0 grants reads and bit 1 grants writes.
- R2: The entry used for a lookup is the one at index `req_addr >> PAGE_SHIFT`. The lookup is in range only when that index is less than `NUM_ENTRIES`.
- R3: An out-of-range lookup returns `rsp_iova` = 0, `rsp_phys` = 0, `rsp_mask` = all ones, `rsp_perm` = 0 and `rsp_fault` = 1.
- R4: An in-range lookup returns `rsp_iova` equal to `req_addr` with its low `PAGE_SHIFT` bits cleared.
- R5: An in-range lookup returns `rsp_phys` equal to the entry with its low `PAGE_SHIFT` bits cleared, and `rsp_mask` equal to `2**PAGE_SHIFT - 1`.
- R6: Reset clears every entry to zero, so every in-range lookup after reset returns permission 0 and faults until an update writes the entry.
- R7: `rsp_fault` is 1 for a write whose entry lacks bit 1, and for a read whose entry lacks bit 0. Otherwise it is 0.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held unconsumed. `rsp_valid` rises on the clock edge that accepts a request. The response stays stable while `rsp_valid` is high and `rsp_ready` is low.
- R9: When an update and a lookup address the same entry in the same cycle, the lookup returns the old entry value. A later lookup returns the new value.
- R10: An update whose index is not less than `NUM_ENTRIES` is dropped and changes no entry. In particular, it does not alias onto a low-numbered entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | ADDR_W | I/O virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester consumes the response |
| rsp_iova | output | ADDR_W | Page-aligned I/O address |
| rsp_phys | output | ENTRY_W | Translated physical address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Granted permission code |
| rsp_fault | output | 1 | Access not permitted |
| upd_en | input | 1 | Table update strobe |
| upd_index | input | UPD_IDX_W | Entry index to update |
| upd_data | input | ENTRY_W | New entry value |

## Verification
The assertions watch the response on every cycle. They check these properties:
- Returned addresses are page aligned.
- A response with an all-ones mask carries zero addresses and no permission.
- A response without permission always faults, and a read-write entry never faults.
- The response arrives in the cycle after acceptance and stays frozen under backpressure.

The bench scenarios show what the assertions cannot:
- Which entry an address selects, and the translated frame value.
- The direction-dependent fault for read-only and write-only pages.
- That reset clears the table.
- That a same-cycle update is not seen by the lookup.
- That an out-of-range update leaves every entry untouched.

// File: rtl/iotx_pkg.sv
package iotx_pkg;

    localparam int unsigned PERM_W = 2;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

endpackage

// File: rtl/iotx_table.sv
// Entry storage: flop array cleared at reset, one write port,
// one registered read port (read-before-write on a collision).
module iotx_table #(
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned ENTRY_W     = 64,
    parameter int unsigned IDX_W       = 4,
    parameter int unsigned UPD_IDX_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [UPD_IDX_W-1:0] wr_idx,
    input  logic [ENTRY_W-1:0]   wr_data,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [ENTRY_W-1:0]   rd_data
);

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] mem;
        logic [ENTRY_W-1:0]                  rd;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic wr_hit;
    logic rd_hit;

    always_comb begin
        wr_hit = wr_en && (32'(wr_idx) < NUM_ENTRIES);
        rd_hit = (32'(rd_idx) < NUM_ENTRIES);
        st_d   = st_q;
        // read uses the registered array, so it sees the old value
        if (rd_en) begin
            st_d.rd = rd_hit ? st_q.mem[rd_idx] : '0;
        end
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (wr_hit && (32'(wr_idx) == e)) begin
                st_d.mem[e] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/iotx_perm.sv
// Permission check against the access direction.
module iotx_perm
    import iotx_pkg::*;
(
    input  perm_e perm,
    input  logic  is_write,
    output logic  fault
);

    logic may_read;
    logic may_write;

    always_comb begin
        may_read  = (perm == PERM_RD) || (perm == PERM_RW);
        may_write = (perm == PERM_WR) || (perm == PERM_RW);
        fault     = is_write ? !may_write : !may_read;
    end

endmodule

// File: rtl/iotx_result.sv
// Forms the translation result from the captured request and the entry.
module iotx_result
    import iotx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned ENTRY_W    = 64,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_write,
    input  logic               in_range,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  iova,
    output logic [ENTRY_W-1:0] phys,
    output logic [ADDR_W-1:0]  mask,
    output logic [PERM_W-1:0]  perm,
    output logic               fault
);

    localparam logic [ADDR_W-1:0]  ADDR_OFF  = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [ENTRY_W-1:0] ENTRY_OFF = ENTRY_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    perm_e perm_eff;

    always_comb begin
        if (in_range) begin
            iova     = addr & ~ADDR_OFF;
            phys     = entry & ~ENTRY_OFF;
            mask     = ADDR_OFF;
            perm_eff = perm_e'(entry[PERM_W-1:0]);
        end else begin
            iova     = '0;
            phys     = '0;
            mask     = '1;
            perm_eff = PERM_NONE;
        end
        perm = perm_eff;
    end

    iotx_perm perm_i (
        .perm     (perm_eff),
        .is_write (is_write),
        .fault    (fault)
    );

endmodule

// File: rtl/iotx_translator.sv
module iotx_translator
    import iotx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned ENTRY_W     = 64,
    parameter int unsigned PAGE_SHIFT  = 12,
    parameter int unsigned NUM_ENTRIES = 16,
    parameter int unsigned IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    parameter int unsigned UPD_IDX_W   = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [ADDR_W-1:0]    rsp_iova,
    output logic [ENTRY_W-1:0]   rsp_phys,
    output logic [ADDR_W-1:0]    rsp_mask,
    output logic [1:0]           rsp_perm,
    output logic                 rsp_fault,
    input  logic                 upd_en,
    input  logic [UPD_IDX_W-1:0] upd_index,
    input  logic [ENTRY_W-1:0]   upd_data
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              in_range;
    } req_state_t;

    req_state_t st_d, st_q;

    logic             accept;
    logic [IDX_W-1:0] rd_idx;
    logic [ENTRY_W-1:0] entry;

    always_comb begin
        req_ready = !st_q.valid || rsp_ready;
        accept    = req_valid && req_ready;
        rd_idx    = IDX_W'(req_addr >> PAGE_SHIFT);
        st_d      = st_q;
        if (accept) begin
            st_d.valid    = 1'b1;
            st_d.addr     = req_addr;
            st_d.write    = req_write;
            st_d.in_range = (req_addr >> PAGE_SHIFT) < ADDR_W'(NUM_ENTRIES);
        end else if (rsp_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    iotx_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ENTRY_W     (ENTRY_W),
        .IDX_W       (IDX_W),
        .UPD_IDX_W   (UPD_IDX_W)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd_en),
        .wr_idx  (upd_index),
        .wr_data (upd_data),
        .rd_en   (accept),
        .rd_idx  (rd_idx),
        .rd_data (entry)
    );

    iotx_result #(
        .ADDR_W     (ADDR_W),
        .ENTRY_W    (ENTRY_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) result_i (
        .addr     (st_q.addr),
        .is_write (st_q.write),
        .in_range (st_q.in_range),
        .entry    (entry),
        .iova     (rsp_iova),
        .phys     (rsp_phys),
        .mask     (rsp_mask),
        .perm     (rsp_perm),
        .fault    (rsp_fault)
    );

    assign rsp_valid = st_q.valid;

endmodule

// File: rtl/iotx_translator_chk.sv
module iotx_translator_chk #(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned ENTRY_W    = 64,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [ADDR_W-1:0]  rsp_iova,
    input logic [ENTRY_W-1:0] rsp_phys,
    input logic [ADDR_W-1:0]  rsp_mask,
    input logic [1:0]         rsp_perm,
    input logic               rsp_fault
);

    localparam logic [ADDR_W-1:0]  A_OFF = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);
    localparam logic [ENTRY_W-1:0] E_OFF = ENTRY_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    // R4 R5
    page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (((rsp_iova & A_OFF) == '0) && ((rsp_phys & E_OFF) == '0)));

    // R3
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_mask == '1)) |->
            ((rsp_iova == '0) && (rsp_phys == '0) && (rsp_perm == 2'd0) && rsp_fault));

    // R7
    no_perm_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_perm == 2'd0)) |-> rsp_fault);

    // R7
    rw_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_perm == 2'd3)) |-> !rsp_fault);

    // R8
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_phys) && $stable(rsp_iova) && $stable(rsp_perm)
             && $stable(rsp_fault) && $stable(rsp_mask)));

    // R8
    ready_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

endmodule

bind iotx_translator iotx_translator_chk #(
    .ADDR_W     (ADDR_W),
    .ENTRY_W    (ENTRY_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_iova  (rsp_iova),
    .rsp_phys  (rsp_phys),
    .rsp_mask  (rsp_mask),
    .rsp_perm  (rsp_perm),
    .rsp_fault (rsp_fault)
);

// File: tb/iotx_translator_tb_top.sv
module iotx_translator_tb_top;

    localparam int ADDR_W = 64;
    localparam int ENTRY_W = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int NUM_ENTRIES = 16;
    localparam int UPD_IDX_W = 5;
    localparam int NV = 9;

    localparam logic [63:0] OFFM = 64'h0000_0000_0000_0FFF;

    // lookup vectors: address, write flag, expected iova, phys, mask, perm, fault
    localparam logic [63:0] V_ADDR [NV] = '{64'h123, 64'h123, 64'h1FFF, 64'h1004,
        64'h2ABC, 64'h2000, 64'hFFFF, 64'h1_0000, 64'h8000_0000_0000_0000};
    localparam logic        V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [63:0] V_IOVA [NV] = '{64'h0, 64'h0, 64'h1000, 64'h1000,
        64'h2000, 64'h2000, 64'hF000, 64'h0, 64'h0};
    localparam logic [63:0] V_PHYS [NV] = '{64'h1234_5000, 64'h1234_5000,
        64'hABCD_E000_0000_0000, 64'hABCD_E000_0000_0000, 64'h8_8000, 64'h8_8000,
        64'h7777_7000, 64'h0, 64'h0};
    localparam logic [63:0] V_MASK [NV] = '{OFFM, OFFM, OFFM, OFFM, OFFM, OFFM, OFFM,
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [1:0]  V_PERM [NV] = '{2'd3, 2'd3, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0};
    localparam logic        V_FLT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic rsp_valid;
    logic rsp_ready = 1'b1;
    logic [ADDR_W-1:0] rsp_iova;
    logic [ENTRY_W-1:0] rsp_phys;
    logic [ADDR_W-1:0] rsp_mask;
    logic [1:0] rsp_perm;
    logic rsp_fault;
    logic upd_en = 1'b0;
    logic [UPD_IDX_W-1:0] upd_index = '0;
    logic [ENTRY_W-1:0] upd_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iotx_translator #(
        .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .PAGE_SHIFT(PAGE_SHIFT),
        .NUM_ENTRIES(NUM_ENTRIES)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_phys(rsp_phys),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .upd_en(upd_en), .upd_index(upd_index), .upd_data(upd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [63:0] data);
        @(negedge clk);
        upd_en = 1'b1;
        upd_index = UPD_IDX_W'(idx);
        upd_data = data;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    // request at a falling edge, accepted at the next rising edge,
    // response sampled at the falling edge after that
    task automatic lookup(input logic [63:0] addr, input logic wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = addr;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_rsp(input string tag, input logic [63:0] iova, input logic [63:0] phys,
                           input logic [63:0] mask, input logic [1:0] perm, input logic flt);
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " iova"}, rsp_iova, iova);
        chk({tag, " phys"}, rsp_phys, phys);
        chk({tag, " mask"}, rsp_mask, mask);
        chk({tag, " perm"}, 64'(rsp_perm), 64'(perm));
        chk({tag, " fault"}, 64'(rsp_fault), 64'(flt));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 idle state after reset
        chk("R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R8 reset req_ready", 64'(req_ready), 64'd1);
        // R6 cleared table: in range but no permission
        lookup(64'h3456, 1'b0);
        chk_rsp("R6 cleared", 64'h3000, 64'h0, OFFM, 2'd0, 1'b1);

        // R1 R2 table fill
        put(0, 64'h1234_5003);
        put(1, 64'hABCD_E000_0000_0FF1);
        put(2, 64'h8_8002);
        put(15, 64'h7777_7ABC);

        // R1 R2 R3 R4 R5 R7 vector walk
        for (int v = 0; v < NV; v++) begin
            lookup(V_ADDR[v], V_WR[v]);
            chk_rsp($sformatf("R1/R2/R3/R4/R5/R7 vec%0d", v), V_IOVA[v], V_PHYS[v],
                    V_MASK[v], V_PERM[v], V_FLT[v]);
        end

        // R9 same-cycle update and lookup of entry 3
        @(negedge clk);
        upd_en = 1'b1; upd_index = 5'd3; upd_data = 64'h5555_5003;
        req_valid = 1'b1; req_addr = 64'h3010; req_write = 1'b0;
        @(negedge clk);
        upd_en = 1'b0; req_valid = 1'b0;
        chk_rsp("R9 old value", 64'h3000, 64'h0, OFFM, 2'd0, 1'b1);
        lookup(64'h3010, 1'b1);
        chk_rsp("R9 new value", 64'h3000, 64'h5555_5000, OFFM, 2'd3, 1'b0);

        // R10 update index 16 must not touch entry 0
        put(16, 64'hDEAD_0000);
        lookup(64'h0, 1'b0);
        chk_rsp("R10 entry0 kept", 64'h0, 64'h1234_5000, OFFM, 2'd3, 1'b0);

        // R8 backpressure hold
        @(negedge clk);
        rsp_ready = 1'b0;
        lookup(64'h1000, 1'b0);
        chk("R8 ready low while held", 64'(req_ready), 64'd0);
        held = rsp_phys;
        repeat (3) @(negedge clk);
        chk("R8 held valid", 64'(rsp_valid), 64'd1);
        chk("R8 held phys", rsp_phys, held);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R8 drained", 64'(rsp_valid), 64'd0);

        // R6 second reset clears written entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(64'h0, 1'b0);
        chk_rsp("R6 after reset", 64'h0, 64'h0, OFFM, 2'd0, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule